// File: doc/BRIEF.md
# Dual-Rail Coherence-Gated Register

This block is a multi-bit state register in which every data bit, the stage clock and every output travel on two rails: a true rail and a complement rail. Each bit is a master-slave pair of storage stages. The master opens in one phase of the dual-rail stage clock and the slave opens in the other.

A stage accepts a new value only when two conditions both hold. Its data rails must be complementary, and the clock rails must name a valid phase. On any disagreement the stage keeps what it already holds. A corrupted value is therefore stopped at the first stage instead of being outvoted later, and the block needs no voter and no replicated copy.

The stages are modelled as registers on a free-running system clock `clk`. The dual-rail stage clock is sampled on each rising edge of `clk`. Each bit checks its own rails, so one bad bit never stalls the others. A per-bit flag reports input rails that agree with each other.

Top module: `railcheck_reg`

## Requirements
- R1: On a rising `clk` edge with `rst` high, the block resets. After that edge, `q_t` is all zeros, `q_c` is all ones and `mis` is all zeros.
- R2: An edge is a master phase when `ck_t`=0 and `ck_c`=1. On such an edge, each bit whose data rails are complementary loads `d_t` into its master stage, and `q_t`/`q_c` do not change.
- R3: An edge is a slave phase when `ck_t`=1 and `ck_c`=0. On such an edge, `q_t` takes the value held in the master stage and `q_c` takes its complement.
- R4: If bit i has `d_t[i]` equal to `d_c[i]` on a master-phase edge, that bit's master keeps its old value. Every bit with complementary rails still loads its new value.
- R5: If `ck_t` equals `ck_c` (both 0 or both 1), neither stage of any bit changes. A later slave phase therefore shows the master value captured before the invalid phase.
- R6: `mis[i]` is 1 after an edge at which `d_t[i]` equalled `d_c[i]`, and 0 after an edge at which they differed. This holds regardless of the clock phase.
- R7: Outside reset, `q_c` is always the bitwise complement of `q_t`.
- R8: Data applied only during slave-phase edges has no effect on `q_t`/`q_c`, because the master stage is closed then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all rails |
| rst | input | 1 | Synchronous active-high reset |
| ck_t | input | 1 | Stage clock, true rail |
| ck_c | input | 1 | Stage clock, complement rail |
| d_t | input | W | Data, true rails |
| d_c | input | W | Data, complement rails |
| q_t | output | W | Stored value, true rails |
| q_c | output | W | Stored value, complement rails |
| mis | output | W | Per-bit flag: input rails agreed at the last edge |

## Verification
A wrong master value stays hidden during master phases. It shows at `q_t`/`q_c` on the first slave-phase edge after it was captured, so every check of a load is paired with a following slave phase. A stage that wrongly opens on an invalid or opposite clock phase shows as an output change one edge early. A stage that ignores the coherence check shows as one flagged bit taking a new value while the other bits load normally. Any stored state that is not complementary shows at once as `q_c` failing to mirror `q_t`.

// File: rtl/railcheck_pkg.sv
package railcheck_pkg;

    // One dual-rail bit: a true rail and a complement rail.
    typedef struct packed {
        logic t;
        logic c;
    } rail_t;

    // Decoded meaning of the two stage-clock rails.
    typedef enum logic [1:0] {
        PH_INVALID = 2'd0,
        PH_MASTER  = 2'd1,
        PH_SLAVE   = 2'd2
    } phase_e;

    // A rail pair is usable only when its rails disagree.
    function automatic logic rail_ok(input rail_t r);
        return r.t ^ r.c;
    endfunction

    // Value a stage holds after reset: logical zero.
    function automatic rail_t rail_zero();
        rail_t r;
        r.t = 1'b0;
        r.c = 1'b1;
        return r;
    endfunction

    // Map the clock rails to a phase. Equal rails never open a stage.
    function automatic phase_e clock_phase(input logic t, input logic c);
        phase_e p;
        if (!t && c)
            p = PH_MASTER;
        else if (t && !c)
            p = PH_SLAVE;
        else
            p = PH_INVALID;
        return p;
    endfunction

endpackage

// File: rtl/railcheck_phase.sv
module railcheck_phase
    import railcheck_pkg::*;
(
    input  logic   ck_t,
    input  logic   ck_c,
    output phase_e ph
);

    always_comb begin
        ph = clock_phase(ck_t, ck_c);
    end

endmodule

// File: rtl/railcheck_stage.sv
module railcheck_stage
    import railcheck_pkg::*;
#(
    parameter phase_e OPEN_ON = PH_MASTER
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_e ph,
    input  rail_t  din,
    output rail_t  dout
);

    logic take;

    // The stage opens only in its own phase and only for coherent rails.
    always_comb begin
        take = (ph == OPEN_ON) && rail_ok(din);
    end

    always_ff @(posedge clk) begin
        if (rst)
            dout <= rail_zero();
        else if (take)
            dout <= din;
    end

endmodule

// File: rtl/railcheck_cell.sv
module railcheck_cell
    import railcheck_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e ph,
    input  rail_t  din,
    output rail_t  dout,
    output logic   bad
);

    rail_t mid;

    railcheck_stage #(.OPEN_ON(PH_MASTER)) u_master (
        .clk  (clk),
        .rst  (rst),
        .ph   (ph),
        .din  (din),
        .dout (mid)
    );

    railcheck_stage #(.OPEN_ON(PH_SLAVE)) u_slave (
        .clk  (clk),
        .rst  (rst),
        .ph   (ph),
        .din  (mid),
        .dout (dout)
    );

    // The flag reports agreeing input rails whatever the clock phase.
    always_ff @(posedge clk) begin
        if (rst)
            bad <= 1'b0;
        else
            bad <= ~rail_ok(din);
    end

endmodule

// File: rtl/railcheck_reg.sv
module railcheck_reg
    import railcheck_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ck_t,
    input  logic         ck_c,
    input  logic [W-1:0] d_t,
    input  logic [W-1:0] d_c,
    output logic [W-1:0] q_t,
    output logic [W-1:0] q_c,
    output logic [W-1:0] mis
);

    phase_e ph;

    railcheck_phase u_phase (
        .ck_t (ck_t),
        .ck_c (ck_c),
        .ph   (ph)
    );

    // One independent cell per bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        rail_t bit_in;
        rail_t bit_out;

        always_comb begin
            bit_in.t = d_t[i];
            bit_in.c = d_c[i];
        end

        railcheck_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .ph   (ph),
            .din  (bit_in),
            .dout (bit_out),
            .bad  (mis[i])
        );

        assign q_t[i] = bit_out.t;
        assign q_c[i] = bit_out.c;
    end

endmodule

// File: rtl/railcheck_reg_chk.sv
module railcheck_reg_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         ck_t,
    input logic         ck_c,
    input logic [W-1:0] d_t,
    input logic [W-1:0] d_c,
    input logic [W-1:0] q_t,
    input logic [W-1:0] q_c,
    input logic [W-1:0] mis
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (q_t == '0) && (q_c == '1) && (mis == '0)); // R1

    AST_OUT_RAILS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) == 1'b0 |-> (q_c == ~q_t)); // R7

    AST_HOLD_NOT_SLAVE: assert property (@(posedge clk) disable iff (rst)
        !(ck_t && !ck_c) |=> $stable(q_t) && $stable(q_c)); // R2

    AST_HOLD_BAD_CLOCK: assert property (@(posedge clk) disable iff (rst)
        (ck_t == ck_c) |=> $stable(q_t)); // R5

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ((d_t ^ d_c) == '1) |=> (mis == '0)); // R6

endmodule

bind railcheck_reg railcheck_reg_chk #(.W(W)) u_chk (.*);

// File: tb/railcheck_reg_test.sv
module railcheck_reg_test;

    localparam int W = 8;

    typedef struct {
        logic [W-1:0] t;
        logic [W-1:0] c;
        logic [W-1:0] m;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ck_t = 1'b0;
    logic         ck_c = 1'b0;
    logic [W-1:0] d_t = '0;
    logic [W-1:0] d_c = '1;
    logic [W-1:0] q_t, q_c, mis;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_t sb[$];

    // Reference state, built from the requirements.
    logic [W-1:0] m_ref = '0;
    logic [W-1:0] s_ref = '0;
    logic [W-1:0] f_ref = '0;

    railcheck_reg #(.W(W)) uut (
        .clk (clk), .rst (rst), .ck_t (ck_t), .ck_c (ck_c),
        .d_t (d_t), .d_c (d_c), .q_t (q_t), .q_c (q_c), .mis (mis)
    );

    always #5 clk = ~clk;

    // Drive one edge worth of inputs and queue the expected result.
    task automatic step(input logic r, input logic ct, input logic cc,
                        input logic [W-1:0] dt, input logic [W-1:0] dc,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; ck_t = ct; ck_c = cc; d_t = dt; d_c = dc;
        if (r) begin
            m_ref = '0; s_ref = '0; f_ref = '0;
        end else begin
            if (!ct && cc) begin
                for (int i = 0; i < W; i++)
                    if (dt[i] != dc[i]) m_ref[i] = dt[i];
            end else if (ct && !cc) begin
                s_ref = m_ref;
            end
            f_ref = ~(dt ^ dc);
        end
        e.t = s_ref; e.c = ~s_ref; e.m = f_ref; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic load(input logic [W-1:0] v, input string tag);
        step(1'b0, 1'b0, 1'b1, v, ~v, tag);
    endtask

    task automatic show(input logic [W-1:0] v, input string tag);
        step(1'b0, 1'b1, 1'b0, v, ~v, tag);
    endtask

    // Monitor: compare each queued item after its edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (q_t !== e.t || q_c !== e.c || mis !== e.m) begin
                    failures++;
                    $display("FAIL %s: q_t=%h q_c=%h mis=%h expected q_t=%h q_c=%h mis=%h",
                             e.tag, q_t, q_c, mis, e.t, e.c, e.m);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R1 reset");
        step(1'b1, 1'b1, 1'b1, 8'hFF, 8'h00, "R1 reset hold");
        // R2 master loads, outputs unchanged
        load(8'hA5, "R2 master load, output steady");
        load(8'hA5, "R2 second master edge");
        // R3 slave shows master value
        show(8'h00, "R3 slave transfer");
        // R8 data during slave phase ignored
        show(8'h3C, "R8 slave-phase data ignored");
        step(1'b0, 1'b1, 1'b1, 8'h3C, 8'hC3, "R5 equal clock rails");
        show(8'h3C, "R8 output still old value");
        // R4 per-bit gating: bit1 both 1, bit6 both 0
        step(1'b0, 1'b0, 1'b1, 8'h0F, (~8'h0F) ^ 8'h42, "R4 R6 bad bits held");
        show(8'h00, "R4 other bits loaded");
        // R5 invalid clock rails leave both stages alone
        step(1'b0, 1'b1, 1'b1, 8'hFF, 8'h00, "R5 clock rails both one");
        step(1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, "R5 clock rails both zero");
        show(8'h00, "R5 master kept across invalid phase");
        // R6 flag on all rails agreeing, then clear
        step(1'b0, 1'b1, 1'b0, 8'hF0, 8'hF0, "R6 all flags set");
        show(8'h55, "R6 flags clear");
        // Patterns through a full cycle each
        for (int k = 0; k < 8; k++) begin
            logic [W-1:0] v;
            v = 8'h01 << k;
            v = v ^ (8'h93 + 8'(k * 29));
            load(v, "R2 pattern load");
            show(v, "R3 R7 pattern shown");
        end
        // R1 reset in mid run
        load(8'hFF, "R2 load before reset");
        step(1'b1, 1'b1, 1'b0, 8'hFF, 8'h00, "R1 reset mid run");
        show(8'hFF, "R1 master cleared by reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule